// File: doc/BRIEF.md
# TDM Route Bank Swapper

This block controls double-buffered routing tables for a time-division-multiplexed serial port that carries one or two TDM channels. Each channel has a receive table and a transmit table. Each table is split into a current half and a shadow half. There are four lanes in total: A-receive, A-transmit, B-receive and B-transmit. Each lane has one request bit in a command register and one bank bit in a status register.

Software fills the shadow half of a table and then writes a 1 to that lane's request bit. The block waits for the lane's next frame-sync pulse. On that pulse it flips the lane's bank bit and clears the request bit in the same clock, so no frame ever uses entries from both halves. A small combinational mapper turns a lane, a current/shadow select and an entry index into a physical table address. The mapping depends on the division mode.

Top module: `tdm_bank_swapper`

## Requirements
- R1: After reset, `cmd_q` and `stat_q` both read 0x00, so the lower half is current for every lane.
- R2: The lane-to-bit order is fixed: bit 7 is A-receive, bit 6 is A-transmit, bit 5 is B-receive and bit 4 is B-transmit, in both `cmd_q` and `stat_q`. A host write with a 1 in an enabled lane's bit sets that request on the next clock edge. Bits 3:0 of both registers always read 0.
- R3: A host write of 0 to a pending request bit has no effect. Only a completed swap clears it.
- R4: When a lane's request is pending and its `frame_sync` bit is high at a clock edge, that edge toggles the lane's status bit and clears its request bit together. `swap_evt` for that lane is high during that cycle.
- R5: Each lane swaps on its own `frame_sync` bit only. A frame sync on one lane never changes another lane's request or bank.
- R6: When `div_mode` is 00 or 10, host writes are ignored, no swap occurs and both registers hold their values.
- R7: When `div_mode` is 01 (one TDM), the B-lane request bits cannot be set and the B lanes never swap.
- R8: A host write of 1 in the same cycle as that lane's completing swap leaves the request set, which arms another swap.
- R9: When `div_mode` is 01, `map_addr` = bank × 64 + `map_index`. Here bank is the lane's status bit XOR `map_shadow`.
- R10: When `div_mode` is 11, `map_addr` = 64 × (lane is B) + 32 × bank + (`map_index` mod 32), with bank defined as in R9. `map_lane` selects the lane: 3 = A-receive, 2 = A-transmit, 1 = B-receive, 0 = B-transmit.
- R11: When `div_mode` is 00 or 10, `map_addr` equals `map_index` zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_mode | input | 2 | Division mode: 01 one TDM, 11 two TDMs, other values inactive |
| cmd_we | input | 1 | Host write strobe for the command register |
| cmd_wdata | input | 8 | Host write data; bits 7:4 are request bits |
| frame_sync | input | 4 | Per-lane frame boundary pulse, bit i = lane i |
| cmd_q | output | 8 | Command register contents |
| stat_q | output | 8 | Status register contents (current bank per lane) |
| swap_evt | output | 4 | Per-lane pulse in the cycle a swap completes |
| map_lane | input | 2 | Lane whose table is being addressed |
| map_shadow | input | 1 | 0 addresses the current half, 1 the shadow half |
| map_index | input | 6 | Entry index within the half |
| map_addr | output | 7 | Physical table address |

## Verification
A wrong request or bank flop shows on `cmd_q` or `stat_q` at the first clock edge after the stimulus that should have changed it, or should have left it alone. If a bank bit is wrong, `map_addr` also jumps by 32 or 64 in the same cycle, so an address check exposes a stale bank at once. A swap that fires on the wrong lane or without a frame sync flips a status bit that the neighbouring lanes' expected values pin down within one cycle.

// File: rtl/tdm_swap_pkg.sv
package tdm_swap_pkg;
  localparam int LANES  = 4;
  localparam int IDX_W  = 6;
  localparam int ADDR_W = IDX_W + 1;
  localparam int REG_W  = 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int REQ_LSB = REG_W - LANES;

  typedef enum logic [1:0] {
    DIV_IDLE0 = 2'b00,
    DIV_ONE   = 2'b01,
    DIV_IDLE2 = 2'b10,
    DIV_TWO   = 2'b11
  } div_mode_e;

  // lanes 3,2 belong to channel A; 1,0 to channel B
  function automatic logic lane_is_b(input int lane);
    return lane < (LANES / 2);
  endfunction

  function automatic logic lane_enabled(input logic [1:0] mode, input int lane);
    return (mode == DIV_TWO) || ((mode == DIV_ONE) && !lane_is_b(lane));
  endfunction

  function automatic logic [ADDR_W-1:0] route_addr(
      input logic [1:0] mode, input logic is_b, input logic bank,
      input logic [IDX_W-1:0] idx);
    logic [ADDR_W-1:0] a;
    case (mode)
      DIV_ONE: a = {bank, idx};
      DIV_TWO: a = {is_b, bank, idx[IDX_W-2:0]};
      default: a = {1'b0, idx};
    endcase
    return a;
  endfunction
endpackage

// File: rtl/tdm_swap_lane.sv
module tdm_swap_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic lane_en,
  input  logic set_req,
  input  logic fsync,
  output logic req_q,
  output logic bank_q,
  output logic swap_o
);
  logic req_d, bank_d;

  assign swap_o = lane_en & req_q & fsync;

  always_comb begin
    req_d  = req_q;
    bank_d = bank_q;
    if (lane_en) begin
      req_d  = (req_q & ~swap_o) | set_req;
      bank_d = bank_q ^ swap_o;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      bank_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      bank_q <= bank_d;
    end
  end
endmodule

// File: rtl/tdm_route_map.sv
module tdm_route_map
  import tdm_swap_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int IW      = IDX_W,
  parameter int AW      = ADDR_W,
  parameter int LW      = LANE_W
) (
  input  logic [1:0]       mode,
  input  logic [N_LANES-1:0] bank_vec,
  input  logic [LW-1:0]    lane,
  input  logic             shadow,
  input  logic [IW-1:0]    idx,
  output logic [AW-1:0]    addr
);
  logic sel_bank;
  logic sel_is_b;

  assign sel_bank = bank_vec[lane] ^ shadow;
  assign sel_is_b = (int'(lane) < (N_LANES / 2));
  assign addr     = route_addr(mode, sel_is_b, sel_bank, idx);
endmodule

// File: rtl/tdm_bank_swapper.sv
module tdm_bank_swapper
  import tdm_swap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        div_mode,
  input  logic              cmd_we,
  input  logic [REG_W-1:0]  cmd_wdata,
  input  logic [LANES-1:0]  frame_sync,
  output logic [REG_W-1:0]  cmd_q,
  output logic [REG_W-1:0]  stat_q,
  output logic [LANES-1:0]  swap_evt,
  input  logic [LANE_W-1:0] map_lane,
  input  logic              map_shadow,
  input  logic [IDX_W-1:0]  map_index,
  output logic [ADDR_W-1:0] map_addr
);
  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] set_req;
  logic [LANES-1:0] req_vec;
  logic [LANES-1:0] bank_vec;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = lane_enabled(div_mode, i);
    assign set_req[i] = cmd_we & lane_en[i] & cmd_wdata[REQ_LSB + i];

    tdm_swap_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .lane_en(lane_en[i]),
      .set_req(set_req[i]),
      .fsync  (frame_sync[i]),
      .req_q  (req_vec[i]),
      .bank_q (bank_vec[i]),
      .swap_o (swap_evt[i])
    );
  end

  assign cmd_q  = {req_vec,  {REQ_LSB{1'b0}}};
  assign stat_q = {bank_vec, {REQ_LSB{1'b0}}};

  tdm_route_map u_map (
    .mode    (div_mode),
    .bank_vec(bank_vec),
    .lane    (map_lane),
    .shadow  (map_shadow),
    .idx     (map_index),
    .addr    (map_addr)
  );
endmodule

// File: rtl/tdm_bank_swapper_chk.sv
module tdm_bank_swapper_chk
  import tdm_swap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        div_mode,
  input logic [LANES-1:0]  frame_sync,
  input logic [REG_W-1:0]  cmd_q,
  input logic [REG_W-1:0]  stat_q,
  input logic [LANES-1:0]  swap_evt
);
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R4: a swap flips the bank bit and drops the request
    assert_swap_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
      swap_evt[i] |=> (stat_q[REQ_LSB+i] != $past(stat_q[REQ_LSB+i])));
    // R4: a swap needs a pending request and a frame sync on its own lane
    assert_swap_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      swap_evt[i] |-> (cmd_q[REQ_LSB+i] && frame_sync[i]));
    // R3: a pending request survives until its swap
    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q[REQ_LSB+i] && !swap_evt[i]) |=> cmd_q[REQ_LSB+i]);
    // R5: the bank changes only through this lane's swap
    assert_bank_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !swap_evt[i] |=> $stable(stat_q[REQ_LSB+i]));
  end

  // R6: inactive modes never swap
  assert_idle_no_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_mode[0] == 1'b0) |-> (swap_evt == '0));
  // R7: single-TDM mode never swaps channel B lanes
  assert_single_no_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_mode == 2'b01) |-> (swap_evt[1:0] == 2'b00));
endmodule

bind tdm_bank_swapper tdm_bank_swapper_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .div_mode  (div_mode),
  .frame_sync(frame_sync),
  .cmd_q     (cmd_q),
  .stat_q    (stat_q),
  .swap_evt  (swap_evt)
);

// File: tb/tdm_bank_swapper_test.sv
module tdm_bank_swapper_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div_mode = 2'b00;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_wdata = 8'h00;
  logic [3:0] frame_sync = 4'h0;
  logic [7:0] cmd_q, stat_q;
  logic [3:0] swap_evt;
  logic [1:0] map_lane = 2'd0;
  logic       map_shadow = 1'b0;
  logic [5:0] map_index = 6'd0;
  logic [6:0] map_addr;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_bank_swapper uut (
    .clk(clk), .rst_n(rst_n), .div_mode(div_mode), .cmd_we(cmd_we),
    .cmd_wdata(cmd_wdata), .frame_sync(frame_sync), .cmd_q(cmd_q),
    .stat_q(stat_q), .swap_evt(swap_evt), .map_lane(map_lane),
    .map_shadow(map_shadow), .map_index(map_index), .map_addr(map_addr)
  );

  // {mode, we, wdata[7:4], fsync, exp cmd[7:4], exp stat[7:4]}
  localparam logic [18:0] VEC [NVEC] = '{
    {2'b01, 1'b1, 4'b1000, 4'b0000, 4'b1000, 4'b0000}, // R2 set A-rx
    {2'b01, 1'b0, 4'b0000, 4'b0100, 4'b1000, 4'b0000}, // R5 other lane sync
    {2'b01, 1'b0, 4'b0000, 4'b1000, 4'b0000, 4'b1000}, // R4 swap A-rx
    {2'b01, 1'b1, 4'b0100, 4'b0000, 4'b0100, 4'b1000}, // R2 set A-tx
    {2'b01, 1'b1, 4'b0000, 4'b0000, 4'b0100, 4'b1000}, // R3 write 0
    {2'b01, 1'b0, 4'b0000, 4'b0100, 4'b0000, 4'b1100}, // R4 swap A-tx
    {2'b01, 1'b1, 4'b0011, 4'b0000, 4'b0000, 4'b1100}, // R7 B ignored
    {2'b01, 1'b0, 4'b0000, 4'b0011, 4'b0000, 4'b1100}, // R7 B no swap
    {2'b11, 1'b1, 4'b0011, 4'b0000, 4'b0011, 4'b1100}, // R2 set B lanes
    {2'b00, 1'b0, 4'b0000, 4'b1111, 4'b0011, 4'b1100}, // R6 frozen
    {2'b00, 1'b1, 4'b1000, 4'b0000, 4'b0011, 4'b1100}, // R6 write ignored
    {2'b11, 1'b0, 4'b0000, 4'b0001, 4'b0010, 4'b1101}, // R5 B-tx only
    {2'b11, 1'b1, 4'b1000, 4'b0010, 4'b1000, 4'b1111}, // R4 B-rx swap + set
    {2'b11, 1'b1, 4'b1000, 4'b1000, 4'b1000, 4'b0111}, // R8 re-arm
    {2'b11, 1'b0, 4'b0000, 4'b1000, 4'b0000, 4'b1111}, // R8 second swap
    {2'b10, 1'b1, 4'b1111, 4'b1111, 4'b0000, 4'b1111}  // R6 mode 10
  };

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic int ref_addr(input logic [1:0] mode, input int lane,
                                  input int bank, input int idx);
    if (mode == 2'b01) return bank * 64 + idx;
    if (mode == 2'b11) return ((lane < 2) ? 64 : 0) + bank * 32 + (idx % 32);
    return idx;
  endfunction

  task automatic check_map(input string req, input logic [1:0] mode, input int lane,
                           input int shadow, input int idx, input int cur_bank);
    div_mode   = mode;
    map_lane   = lane[1:0];
    map_shadow = shadow[0];
    map_index  = idx[5:0];
    #1;
    check8(req, {1'b0, map_addr}, 8'(ref_addr(mode, lane, cur_bank ^ shadow, idx)));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check8("R1 cmd", cmd_q, 8'h00);
    check8("R1 stat", stat_q, 8'h00);
    rst_n = 1'b1;
    for (int k = 0; k < NVEC; k++) begin
      div_mode   = VEC[k][18:17];
      cmd_we     = VEC[k][16];
      cmd_wdata  = {VEC[k][15:12], 4'b0000};
      frame_sync = VEC[k][11:8];
      @(negedge clk);
      check8($sformatf("R2/R4 cmd vec%0d", k), cmd_q, {VEC[k][7:4], 4'b0000});
      check8($sformatf("R4/R5 stat vec%0d", k), stat_q, {VEC[k][3:0], 4'b0000});
    end
    cmd_we = 1'b0; cmd_wdata = 8'h00; frame_sync = 4'h0;
    // banks now 1111; R9, R10, R11 address mapping
    check_map("R10 A-rx cur", 2'b11, 3, 0, 5, 1);
    check_map("R10 B-rx cur", 2'b11, 1, 0, 31, 1);
    check_map("R10 B-rx shadow", 2'b11, 1, 1, 0, 1);
    check_map("R10 A-tx idx wrap", 2'b11, 2, 1, 33, 1);
    check_map("R9 A-rx cur", 2'b01, 3, 0, 63, 1);
    check_map("R9 A-rx shadow", 2'b01, 3, 1, 63, 1);
    check_map("R11 idle", 2'b00, 3, 0, 10, 1);
    // R1 reset from a busy state
    div_mode = 2'b11; cmd_we = 1'b1; cmd_wdata = 8'hF0;
    @(negedge clk);
    cmd_we = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check8("R1 cmd after reset", cmd_q, 8'h00);
    check8("R1 stat after reset", stat_q, 8'h00);
    rst_n = 1'b1;
    check_map("R1 lower bank current", 2'b01, 3, 0, 0, 0);
    report();
  end
endmodule